// File: doc/BRIEF.md
# Indexed Byte Port With Lockable Windows

This block gives a host an indirect path into a byte-wide memory through a four-location byte port. Two port locations load the low and high bytes of a 16-bit address pointer. A third location moves data at the address the pointer holds. A host first places an address, then reads or writes one byte through the data location. After each data write the pointer returns to zero, so the next transfer starts from a known address.

Two adjacent 16-byte address windows can each be closed by their own lock bit. A separate control input loads the lock bits. Inside a closed window, writes are dropped and reads return all ones. Addresses at or beyond the configured memory size are treated the same way. They are never folded back into the array.

Top module: `byte_window_port`

## Requirements
- R1: A host write to offset 0 replaces pointer bits [7:0] with the written byte and leaves bits [15:8] unchanged.
- R2: A host write to offset 1 replaces pointer bits [15:8] with the written byte and leaves bits [7:0] unchanged.
- R3: A host write to offset 3 stores the byte at the pointer address when that address is accessible, and the pointer becomes 0x0000 afterwards in every case.
- R4: A host read of offset 3 returns the byte at the pointer address on `host_rdata` one clock after the read strobe. `host_rdata` holds that value until the next read.
- R5: A host read of offset 0, 1 or 2 returns 0xFF. A host write to offset 2 changes neither the pointer nor the memory.
- R6: While lock bit 0 is set, addresses 0x20 to 0x2F drop writes and return 0xFF on read. Their stored bytes reappear once the bit is cleared.
- R7: While lock bit 1 is set, addresses 0x30 to 0x3F behave as in R6. Lock bit 1 has no effect on 0x20 to 0x2F, and lock bit 0 has no effect on 0x30 to 0x3F.
- R8: For a pointer value at or above the memory size, writes are dropped and reads return 0xFF. Such a write does not alter the byte at the same address modulo the memory size.
- R9: Synchronous reset clears the pointer and both lock bits, and sets `host_rdata` to 0xFF.
- R10: When `lock_we` is high at a clock edge, the lock bits take the value of `lock_din`. Bit 0 controls the lower window and bit 1 controls the upper window.
- R11: A host read at any offset leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_off | input | 2 | Port offset: 0 pointer low, 1 pointer high, 2 spare, 3 data |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid one clock after the read strobe |
| lock_we | input | 1 | Load enable for the lock bits |
| lock_din | input | 2 | New lock bit values |

## Verification
A write to the pointer, the memory or the lock bits takes effect at the clock edge that samples the strobe. A read result appears on `host_rdata` after that same edge, which gives it one cycle of latency. The bench drives every strobe for a single cycle starting at a falling edge. It samples `host_rdata` at the next falling edge, after the capturing rising edge and before any new stimulus. Pointer and lock state are never probed directly. They are observed through later data-port reads, such as reading address 0 straight after a write or reading a window after it is unlocked.

// File: rtl/bwp_pkg.sv
package bwp_pkg;

    localparam int PTR_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OFF_PTR_LO = 2'd0,
        OFF_PTR_HI = 2'd1,
        OFF_SPARE  = 2'd2,
        OFF_DATA   = 2'd3
    } port_off_e;

    typedef struct packed {
        logic load_lo;
        logic load_hi;
        logic data_wr;
        logic data_rd;
        logic any_rd;
    } host_cmd_t;

    // Replace one byte lane of the pointer, keep the other.
    function automatic logic [PTR_W-1:0] merge_byte(
        input logic [PTR_W-1:0]  old_ptr,
        input logic [BYTE_W-1:0] b,
        input logic              upper
    );
        logic [PTR_W-1:0] r;
        r = old_ptr;
        if (upper) r[PTR_W-1:BYTE_W] = b;
        else       r[BYTE_W-1:0]     = b;
        return r;
    endfunction

    function automatic host_cmd_t decode_cmd(
        input logic [1:0] off,
        input logic       wr,
        input logic       rd
    );
        host_cmd_t c;
        c.load_lo = wr && (port_off_e'(off) == OFF_PTR_LO);
        c.load_hi = wr && (port_off_e'(off) == OFF_PTR_HI);
        c.data_wr = wr && (port_off_e'(off) == OFF_DATA);
        c.data_rd = rd && (port_off_e'(off) == OFF_DATA);
        c.any_rd  = rd;
        return c;
    endfunction

endpackage

// File: rtl/bwp_ptr.sv
module bwp_ptr
    import bwp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic              clear,
    input  logic [BYTE_W-1:0] din,
    output logic [PTR_W-1:0]  ptr_q
);

    always_ff @(posedge clk) begin
        if (rst)          ptr_q <= '0;
        else if (clear)   ptr_q <= '0;
        else if (load_lo) ptr_q <= merge_byte(ptr_q, din, 1'b0);
        else if (load_hi) ptr_q <= merge_byte(ptr_q, din, 1'b1);
    end

endmodule

// File: rtl/bwp_guard.sv
module bwp_guard
    import bwp_pkg::*;
#(
    parameter int MEM_BYTES = 512,
    parameter int LOCK_BITS = 2,
    parameter int WIN_BASE  = 32'h20,
    parameter int WIN_BYTES = 16
) (
    input  logic [PTR_W-1:0]     ptr,
    input  logic [LOCK_BITS-1:0] lock,
    output logic                 access_ok
);

    localparam logic [31:0] LIMIT = 32'(MEM_BYTES);

    logic [31:0]          p32;
    logic [LOCK_BITS-1:0] win_closed;
    logic                 in_range;

    assign p32      = {{(32-PTR_W){1'b0}}, ptr};
    assign in_range = p32 < LIMIT;

    // One comparator pair per window; windows sit back to back.
    for (genvar i = 0; i < LOCK_BITS; i++) begin : g_win
        localparam logic [31:0] LO = 32'(WIN_BASE + i * WIN_BYTES);
        localparam logic [31:0] HI = 32'(WIN_BASE + (i + 1) * WIN_BYTES);
        assign win_closed[i] = lock[i] && (p32 >= LO) && (p32 < HI);
    end

    assign access_ok = in_range && (win_closed == '0);

endmodule

// File: rtl/bwp_store.sv
module bwp_store
    import bwp_pkg::*;
#(
    parameter int MEM_BYTES = 512,
    localparam int AW       = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [AW-1:0]     addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata_q
);

    logic [BYTE_W-1:0] mem [MEM_BYTES];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata_q   <= mem[addr];
    end

endmodule

// File: rtl/byte_window_port.sv
module byte_window_port
    import bwp_pkg::*;
#(
    parameter int MEM_BYTES = 512,
    parameter int LOCK_BITS = 2,
    parameter int WIN_BASE  = 32'h20,
    parameter int WIN_BYTES = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           host_off,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic [7:0]           host_wdata,
    output logic [7:0]           host_rdata,
    input  logic                 lock_we,
    input  logic [LOCK_BITS-1:0] lock_din
);

    localparam int AW = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;

    host_cmd_t            cmd;
    logic [PTR_W-1:0]     ptr_q;
    logic [LOCK_BITS-1:0] lock_q;
    logic                 access_ok;
    logic                 rd_pass_q;
    logic [BYTE_W-1:0]    mem_q;

    assign cmd = decode_cmd(host_off, host_wr, host_rd);

    always_ff @(posedge clk) begin
        if (rst)          lock_q <= '0;
        else if (lock_we) lock_q <= lock_din;
    end

    bwp_ptr u_ptr (
        .clk     (clk),
        .rst     (rst),
        .load_lo (cmd.load_lo),
        .load_hi (cmd.load_hi),
        .clear   (cmd.data_wr),
        .din     (host_wdata),
        .ptr_q   (ptr_q)
    );

    bwp_guard #(
        .MEM_BYTES (MEM_BYTES),
        .LOCK_BITS (LOCK_BITS),
        .WIN_BASE  (WIN_BASE),
        .WIN_BYTES (WIN_BYTES)
    ) u_guard (
        .ptr       (ptr_q),
        .lock      (lock_q),
        .access_ok (access_ok)
    );

    bwp_store #(
        .MEM_BYTES (MEM_BYTES)
    ) u_store (
        .clk     (clk),
        .we      (cmd.data_wr && access_ok),
        .re      (cmd.data_rd && access_ok),
        .addr    (ptr_q[AW-1:0]),
        .wdata   (host_wdata),
        .rdata_q (mem_q)
    );

    // Remembers whether the last read may show the array byte.
    always_ff @(posedge clk) begin
        if (rst)             rd_pass_q <= 1'b0;
        else if (cmd.any_rd) rd_pass_q <= cmd.data_rd && access_ok;
    end

    assign host_rdata = rd_pass_q ? mem_q : 8'hFF;

endmodule

// File: rtl/bwp_checker.sv
module bwp_checker #(
    parameter int LOCK_BITS = 2,
    parameter int WIN_BASE  = 32'h20,
    parameter int WIN_BYTES = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic [1:0]           host_off,
    input logic                 host_wr,
    input logic                 host_rd,
    input logic [7:0]           host_wdata,
    input logic [7:0]           host_rdata,
    input logic [15:0]          ptr_q,
    input logic [LOCK_BITS-1:0] lock_q
);

    localparam logic [31:0] W0_LO = 32'(WIN_BASE);
    localparam logic [31:0] W0_HI = 32'(WIN_BASE + WIN_BYTES);

    logic [31:0] p32;
    assign p32 = {16'b0, ptr_q};

    assert_ptr_low_load_R1: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_off == 2'd0) |=>
            (ptr_q[7:0] == $past(host_wdata) && ptr_q[15:8] == $past(ptr_q[15:8])));

    assert_ptr_high_load_R2: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_off == 2'd1) |=>
            (ptr_q[15:8] == $past(host_wdata) && ptr_q[7:0] == $past(ptr_q[7:0])));

    assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_off == 2'd3) |=> (ptr_q == 16'h0000));

    assert_spare_read_ones_R5: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_off != 2'd3) |=> (host_rdata == 8'hFF));

    assert_low_window_locked_R6: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !host_wr && host_off == 2'd3 && lock_q[0] && p32 >= W0_LO && p32 < W0_HI)
            |=> (host_rdata == 8'hFF));

    assert_reset_state_R9: assert property (@(posedge clk)
        rst |=> (ptr_q == 16'h0000 && lock_q == '0 && host_rdata == 8'hFF));

    assert_read_keeps_ptr_R11: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !host_wr) |=> $stable(ptr_q));

endmodule

bind byte_window_port bwp_checker #(
    .LOCK_BITS (LOCK_BITS),
    .WIN_BASE  (WIN_BASE),
    .WIN_BYTES (WIN_BYTES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_off   (host_off),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .ptr_q      (ptr_q),
    .lock_q     (lock_q)
);

// File: tb/byte_window_port_test.sv
`timescale 1ns/1ps
module byte_window_port_test;

    localparam int MEM = 512;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] host_off = 2'd0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       lock_we = 1'b0;
    logic [1:0] lock_din = 2'b00;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_mem [MEM];
    logic [1:0] lk = 2'b00;

    always #10 clk = ~clk;

    byte_window_port uut (
        .clk(clk), .rst(rst), .host_off(host_off), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .lock_we(lock_we), .lock_din(lock_din)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    function automatic logic ok_addr(input logic [15:0] a, input logic [1:0] l);
        if (a >= MEM) return 1'b0;
        if (l[0] && a >= 16'h20 && a < 16'h30) return 1'b0;
        if (l[1] && a >= 16'h30 && a < 16'h40) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37) + (a >> 8) * 5 + 1);
    endfunction

    task automatic hwrite(input logic [1:0] off, input logic [7:0] v);
        @(negedge clk);
        host_off = off; host_wdata = v; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [1:0] off, output logic [7:0] v);
        @(negedge clk);
        host_off = off; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        v = host_rdata;
    endtask

    task automatic set_ptr(input logic [15:0] a);
        hwrite(2'd0, a[7:0]);
        hwrite(2'd1, a[15:8]);
    endtask

    task automatic set_lock(input logic [1:0] v);
        @(negedge clk);
        lock_we = 1'b1; lock_din = v;
        @(negedge clk);
        lock_we = 1'b0;
        lk = v;
    endtask

    task automatic write_at(input logic [15:0] a, input logic [7:0] v);
        set_ptr(a);
        hwrite(2'd3, v);
        if (ok_addr(a, lk)) exp_mem[a[8:0]] = v;
    endtask

    task automatic read_at(input string req, input logic [15:0] a);
        logic [7:0] got;
        set_ptr(a);
        hread(2'd3, got);
        check(req, got, ok_addr(a, lk) ? exp_mem[a[8:0]] : 8'hFF);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        lk = 2'b00;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] v2;
        do_reset;
        // R9: read byte is all ones straight after reset
        check("R9 rdata after reset", host_rdata, 8'hFF);
        // R9/R3: pointer is zero after reset, so a data write lands at 0
        hwrite(2'd3, 8'h11);
        hread(2'd3, v);
        check("R9 pointer zero after reset", v, 8'h11);
        exp_mem[0] = 8'h11;

        // R3/R4 sweep: fill every address, then read each back
        for (int a = 0; a < MEM; a++) write_at(16'(a), pat(a));
        for (int a = 0; a < MEM; a++) read_at("R4 sweep read", 16'(a));

        // R3: pointer returns to 0 after a data write
        write_at(16'h0123, 8'hA7);
        hread(2'd3, v);
        check("R3 pointer cleared after write", v, exp_mem[0]);

        // R4/R11: repeated reads hold pointer; later write lands there
        set_ptr(16'h0042);
        hread(2'd3, v);
        check("R4 read at 0x42", v, exp_mem[9'h42]);
        hread(2'd0, v);
        check("R5 offset 0 reads ones", v, 8'hFF);
        hread(2'd3, v);
        check("R11 pointer unchanged by reads", v, exp_mem[9'h42]);
        hwrite(2'd3, 8'h3C);
        exp_mem[9'h42] = 8'h3C;
        read_at("R11 write after reads hit 0x42", 16'h0042);
        // R4: output holds between reads
        repeat (3) @(negedge clk);
        check("R4 rdata holds", host_rdata, 8'h3C);

        // R5: other offsets read ones; offset 2 write ignored
        hread(2'd1, v);
        check("R5 offset 1 reads ones", v, 8'hFF);
        hread(2'd2, v);
        check("R5 offset 2 reads ones", v, 8'hFF);
        set_ptr(16'h0005);
        hwrite(2'd2, 8'hAA);
        hread(2'd3, v);
        check("R5 offset 2 write ignored", v, exp_mem[5]);

        // R1/R2: each half-load keeps the other half
        set_ptr(16'h0105);
        hwrite(2'd0, 8'h07);
        hread(2'd3, v);
        check("R1 low load keeps high", v, exp_mem[9'h107]);
        hwrite(2'd1, 8'h00);
        hread(2'd3, v);
        check("R2 high load keeps low", v, exp_mem[9'h007]);

        // R6/R7/R10: lock bit 0 only
        set_lock(2'b01);
        for (int a = 16'h20; a < 16'h40; a++) write_at(16'(a), 8'(a ^ 8'h5A));
        for (int a = 16'h1F; a < 16'h41; a++) read_at("R6 low window locked", 16'(a));
        // lock bit 1 only
        set_lock(2'b10);
        for (int a = 16'h20; a < 16'h40; a++) write_at(16'(a), 8'(a ^ 8'hC3));
        for (int a = 16'h1F; a < 16'h41; a++) read_at("R7 high window locked", 16'(a));
        // R10: both set, then clear; stored bytes reappear
        set_lock(2'b11);
        read_at("R10 both locked low", 16'h0025);
        read_at("R10 both locked high", 16'h0035);
        set_lock(2'b00);
        for (int a = 16'h20; a < 16'h40; a++) read_at("R6 unlocked contents", 16'(a));

        // R8: out-of-range addresses
        write_at(16'h0210, 8'hC3);
        read_at("R8 out of range 0x210", 16'h0210);
        read_at("R8 no alias at 0x010", 16'h0010);
        write_at(16'hFFFF, 8'h12);
        read_at("R8 out of range 0xFFFF", 16'hFFFF);
        read_at("R8 no alias at 0x1FF", 16'h01FF);
        write_at(16'h0200, 8'h34);
        read_at("R8 out of range 0x200", 16'h0200);
        read_at("R8 no alias at 0x000", 16'h0000);

        // R9: mid-run reset clears pointer and locks
        set_ptr(16'h0123);
        set_lock(2'b11);
        do_reset;
        check("R9 rdata after second reset", host_rdata, 8'hFF);
        hwrite(2'd3, 8'h77);
        exp_mem[0] = 8'h77;
        hread(2'd3, v2);
        check("R9 pointer cleared by reset", v2, 8'h77);
        read_at("R9 locks cleared low", 16'h0025);
        read_at("R9 locks cleared high", 16'h0035);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule